// File: doc/BRIEF.md
# Strap-Qualified Pin Float Controller

This block decides, at every reset release, which of three operating modes a microcontroller-style device enters. It synchronizes the reset pin, two bus strobe pins and a small group of strap pins into the local clock domain. When the synchronized reset falls, it takes one look at the straps and strobes. If any strap is low, the device goes to a reserved test mode. If all straps are high and the strobes show the float request pattern (address strobe low, fetch strobe high), the controller starts a qualification window. Otherwise it goes straight to normal operation.

During qualification the strobe pattern must stay in place for a parameterized number of machine-cycle enable pulses. When that count is reached, the controller enters the float mode. In that mode the global pin output-enable is deasserted, so every functional pin is released. The reset-output pin keeps its own always-on enable, and the clock keeps running. If the pattern breaks before the count is reached, the controller falls back to normal mode. Float, test and normal modes are left only when reset is asserted again. While reset is held, the controller requests the weak-high preset of the ports.

The states are RESET, QUALIFY, NORMAL, FLOAT and TEST. The transitions are:
- any state to RESET when the synchronized reset is high;
- RESET to TEST on release with any strap low;
- RESET to QUALIFY on release with all straps high and the pattern present;
- RESET to NORMAL on release in every other case;
- QUALIFY to NORMAL when the pattern breaks;
- QUALIFY to FLOAT on the HOLD_MCYC-th enable pulse with the pattern intact.

Top module: `strap_tristate_ctrl`

## Requirements
- R1: While the synchronized reset is high, the controller is in RESET: `port_preset_o`=1, `pin_oe_o`=1, `float_mode_o`=0 and `test_mode_o`=0. This holds from every state.
- R2: The straps are sampled only on the cycle the synchronized reset is first seen low. Strap levels at any later time change nothing.
- R3: On release, with all straps high and the pattern present (`addr_strobe_i`=0, `fetch_strobe_i`=1), the controller enters QUALIFY. It enters FLOAT on the edge that counts the HOLD_MCYC-th `mcyc_en_i` pulse (default 2), provided the pattern is unbroken.
- R4: If the synchronized pattern breaks during QUALIFY, the controller goes to NORMAL and does not reach FLOAT before the next reset.
- R5: On release, with all straps high but the pattern absent, the controller goes to NORMAL.
- R6: In FLOAT, `pin_oe_o`=0 and `float_mode_o`=1. Strobe, strap and enable activity has no effect there.
- R7: `rstout_oe_o` is 1 in every state, including during power-on reset.
- R8: FLOAT, NORMAL and TEST are held until reset is asserted again. Asserting reset in FLOAT restores `pin_oe_o`=1.
- R9: On release with any strap low, the controller enters TEST (`test_mode_o`=1), whatever the strobes show. At most one of `float_mode_o`, `test_mode_o` and `port_preset_o` is high at a time.
- R10: An input change shows on the outputs after the third rising clock edge: two synchronizer stages, then the state register.
- R11: In QUALIFY, clock cycles without `mcyc_en_i` do not advance the hold count. `mcyc_en_i` is not synchronized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| arst_ni | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_i | input | 1 | Device reset pin level, active high, asynchronous |
| addr_strobe_i | input | 1 | Address strobe pin level; must be low for float entry |
| fetch_strobe_i | input | 1 | Program fetch strobe pin level; must be high for float entry |
| strap_i | input | N_STRAP | Strap pins; all high required, else test mode |
| mcyc_en_i | input | 1 | One-clock pulse per machine cycle |
| pin_oe_o | output | 1 | Global output-enable of functional pins, low only in FLOAT |
| rstout_oe_o | output | 1 | Enable of the reset-output pin, always high |
| float_mode_o | output | 1 | High in FLOAT |
| test_mode_o | output | 1 | High in TEST |
| port_preset_o | output | 1 | High in RESET; requests weak-high port preset |

## Verification
The release decision is tried with four input patterns:
- full pattern with all straps high, which separates the float path from normal;
- pattern broken after one counted machine cycle, which shows the hold is enforced;
- one strap low under a valid pattern, which shows test takes priority over the strobes;
- straps high with the address strobe high, which gives plain normal.

Later strap, strobe and enable activity in each resulting mode shows that only the release cycle matters. A stretch of QUALIFY with no enable pulses shows that the count is tied to machine cycles, not clocks. A behavioural model compares all outputs on every clock, so the three-edge latency is checked as well.

// File: rtl/stc_pkg.sv
package stc_pkg;

    typedef enum logic [2:0] {
        ST_RESET   = 3'd0,
        ST_QUALIFY = 3'd1,
        ST_NORMAL  = 3'd2,
        ST_FLOAT   = 3'd3,
        ST_TEST    = 3'd4
    } stc_state_e;

endpackage

// File: rtl/stc_sync.sv
module stc_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         arst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        always_ff @(posedge clk_i or negedge arst_ni) begin
            if (!arst_ni) begin
                meta_q[gi] <= RST_VAL[gi];
                sync_q[gi] <= RST_VAL[gi];
            end else begin
                meta_q[gi] <= d_i[gi];
                sync_q[gi] <= meta_q[gi];
            end
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/stc_hold_cnt.sv
module stc_hold_cnt #(
    parameter int HOLD = 2
) (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic clr_i,
    input  logic tick_i,
    output logic done_o
);

    localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] cnt_q;

    assign done_o = tick_i && (cnt_q == LAST);

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (tick_i && !done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/strap_tristate_ctrl.sv
module strap_tristate_ctrl
    import stc_pkg::*;
#(
    parameter int N_STRAP   = 3,
    parameter int HOLD_MCYC = 2
) (
    input  logic               clk_i,
    input  logic               arst_ni,
    input  logic               rst_pin_i,
    input  logic               addr_strobe_i,
    input  logic               fetch_strobe_i,
    input  logic [N_STRAP-1:0] strap_i,
    input  logic               mcyc_en_i,
    output logic               pin_oe_o,
    output logic               rstout_oe_o,
    output logic               float_mode_o,
    output logic               test_mode_o,
    output logic               port_preset_o
);

    localparam int SW = N_STRAP + 3;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b1, 1'b0, {N_STRAP{1'b1}}};

    logic [SW-1:0]      pins_raw;
    logic [SW-1:0]      pins_s;
    logic               rst_s;
    logic               astb_s;
    logic               fstb_s;
    logic [N_STRAP-1:0] strap_s;
    logic               rst_q;
    logic               rel_edge;
    logic               strap_ok;
    logic               pat_ok;
    logic               hold_clr;
    logic               hold_tick;
    logic               hold_done;

    stc_state_e state_q;
    stc_state_e state_d;

    // Input synchronizer for all pin levels
    assign pins_raw = {rst_pin_i, addr_strobe_i, fetch_strobe_i, strap_i};

    stc_sync #(
        .W       (SW),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk_i   (clk_i),
        .arst_ni (arst_ni),
        .d_i     (pins_raw),
        .q_o     (pins_s)
    );

    assign rst_s   = pins_s[SW-1];
    assign astb_s  = pins_s[SW-2];
    assign fstb_s  = pins_s[SW-3];
    assign strap_s = pins_s[N_STRAP-1:0];

    // Release edge of the synchronized reset
    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            rst_q <= 1'b1;
        end else begin
            rst_q <= rst_s;
        end
    end

    assign rel_edge = rst_q && !rst_s;
    assign strap_ok = &strap_s;
    assign pat_ok   = !astb_s && fstb_s;

    // Machine-cycle hold qualifier
    assign hold_clr  = (state_q != ST_QUALIFY);
    assign hold_tick = (state_q == ST_QUALIFY) && pat_ok && mcyc_en_i;

    stc_hold_cnt #(
        .HOLD (HOLD_MCYC)
    ) u_hold (
        .clk_i   (clk_i),
        .arst_ni (arst_ni),
        .clr_i   (hold_clr),
        .tick_i  (hold_tick),
        .done_o  (hold_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (rst_s) begin
            state_d = ST_RESET;
        end else begin
            unique case (state_q)
                ST_RESET: begin
                    if (rel_edge) begin
                        if (!strap_ok) begin
                            state_d = ST_TEST;
                        end else if (pat_ok) begin
                            state_d = ST_QUALIFY;
                        end else begin
                            state_d = ST_NORMAL;
                        end
                    end
                end
                ST_QUALIFY: begin
                    if (!pat_ok) begin
                        state_d = ST_NORMAL;
                    end else if (hold_done) begin
                        state_d = ST_FLOAT;
                    end
                end
                ST_NORMAL: state_d = ST_NORMAL;
                ST_FLOAT:  state_d = ST_FLOAT;
                ST_TEST:   state_d = ST_TEST;
                default:   state_d = ST_RESET;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from state
    always_comb begin
        pin_oe_o      = 1'b1;
        float_mode_o  = 1'b0;
        test_mode_o   = 1'b0;
        port_preset_o = 1'b0;
        unique case (state_q)
            ST_RESET:   port_preset_o = 1'b1;
            ST_QUALIFY: pin_oe_o      = 1'b1;
            ST_NORMAL:  pin_oe_o      = 1'b1;
            ST_FLOAT: begin
                pin_oe_o     = 1'b0;
                float_mode_o = 1'b1;
            end
            ST_TEST:    test_mode_o   = 1'b1;
            default:    port_preset_o = 1'b1;
        endcase
    end

    assign rstout_oe_o = 1'b1;

endmodule

// File: rtl/strap_tristate_ctrl_chk.sv
module strap_tristate_ctrl_chk
    import stc_pkg::*;
(
    input logic       clk_i,
    input logic       arst_ni,
    input stc_state_e state_i,
    input logic       rst_s_i,
    input logic       astb_s_i,
    input logic       fstb_s_i,
    input logic       mcyc_i,
    input logic       float_i,
    input logic       test_i,
    input logic       preset_i
);

    // R1: synchronized reset forces RESET on the next edge
    p_reset_entry_r1: assert property (@(posedge clk_i) disable iff (!arst_ni)
        rst_s_i |=> (state_i == ST_RESET));

    // R2: test mode is held while reset stays low
    p_test_holds_r2: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (state_i == ST_TEST && !rst_s_i) |=> (state_i == ST_TEST));

    // R3: float is only reached from qualification
    p_float_from_qual_r3: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (state_i == ST_FLOAT && $past(state_i) != ST_FLOAT) |-> ($past(state_i) == ST_QUALIFY));

    // R4: a broken pattern in qualification leads to normal
    p_break_to_normal_r4: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (state_i == ST_QUALIFY && !rst_s_i && (astb_s_i || !fstb_s_i)) |=> (state_i == ST_NORMAL));

    // R5: qualification starts only with the pattern present
    p_qual_entry_r5: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (state_i == ST_QUALIFY && $past(state_i) == ST_RESET) |-> $past(!astb_s_i && fstb_s_i));

    // R8: float is left only through reset
    p_float_holds_r8: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (state_i == ST_FLOAT && !rst_s_i) |=> (state_i == ST_FLOAT));

    // R9: mode flags never overlap
    p_flags_exclusive_r9: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $onehot0({float_i, test_i, preset_i}));

    // R11: no float entry on a clock without a machine-cycle pulse
    p_no_count_r11: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (state_i == ST_QUALIFY && !mcyc_i && !rst_s_i) |=> (state_i != ST_FLOAT));

endmodule

bind strap_tristate_ctrl strap_tristate_ctrl_chk u_chk (
    .clk_i    (clk_i),
    .arst_ni  (arst_ni),
    .state_i  (state_q),
    .rst_s_i  (rst_s),
    .astb_s_i (astb_s),
    .fstb_s_i (fstb_s),
    .mcyc_i   (mcyc_en_i),
    .float_i  (float_mode_o),
    .test_i   (test_mode_o),
    .preset_i (port_preset_o)
);

// File: tb/strap_tristate_ctrl_test.sv
module strap_tristate_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 2;

    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic       rst_pin = 1'b1;
    logic       a_pin = 1'b1;
    logic       f_pin = 1'b0;
    logic [2:0] strap = 3'b111;
    logic       mcyc = 1'b0;

    logic pin_oe, rstout_oe, float_mode, test_mode, port_preset;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    // model state: 0 reset, 1 qualify, 2 normal, 3 float, 4 test
    int         m_st  = 0;
    int         m_cnt = 0;
    logic [5:0] pipe[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    strap_tristate_ctrl #(
        .N_STRAP   (3),
        .HOLD_MCYC (HOLD)
    ) uut (
        .clk_i          (clk),
        .arst_ni        (arst_n),
        .rst_pin_i      (rst_pin),
        .addr_strobe_i  (a_pin),
        .fetch_strobe_i (f_pin),
        .strap_i        (strap),
        .mcyc_en_i      (mcyc),
        .pin_oe_o       (pin_oe),
        .rstout_oe_o    (rstout_oe),
        .float_mode_o   (float_mode),
        .test_mode_o    (test_mode),
        .port_preset_o  (port_preset)
    );

    task automatic check(input int actual, input int expected, input string req, input string what);
        n_checks++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic model_step();
        logic [5:0] old;
        if (!arst_n) begin
            m_st  = 0;
            m_cnt = 0;
            pipe.delete();
            pipe.push_back(6'b110111);
            pipe.push_back(6'b110111);
        end else begin
            old = pipe[0];
            if (old[5]) begin
                m_st  = 0;
                m_cnt = 0;
            end else begin
                case (m_st)
                    0: begin
                        m_cnt = 0;
                        if (old[2:0] != 3'b111)     m_st = 4;
                        else if (!old[4] && old[3]) m_st = 1;
                        else                        m_st = 2;
                    end
                    1: begin
                        if (old[4] || !old[3]) m_st = 2;
                        else if (mcyc) begin
                            if (m_cnt == HOLD - 1) m_st = 3;
                            else m_cnt++;
                        end
                    end
                    default: ;
                endcase
            end
            void'(pipe.pop_front());
            pipe.push_back({rst_pin, a_pin, f_pin, strap});
        end
    endtask

    task automatic compare_all();
        logic [4:0] exp_v;
        logic [4:0] act_v;
        exp_v = {m_st != 3, 1'b1, m_st == 3, m_st == 4, m_st == 0};
        act_v = {pin_oe, rstout_oe, float_mode, test_mode, port_preset};
        check(int'(act_v), int'(exp_v), cur_req, "model compare {oe,rstout,float,test,preset}");
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            #1;
            compare_all();
            @(negedge clk);
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            mcyc = 1'b1;
            tick(1);
            mcyc = 1'b0;
            tick(1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog expired: actual running expected finished");
        finish_run();
    end

    initial begin
        model_step();
        @(negedge clk);
        // Power-on and reset state
        cur_req = "R1";
        tick(3);
        arst_n = 1'b1;
        tick(4);
        check(port_preset, 1, "R1", "preset during reset");
        check(pin_oe, 1, "R1", "pins enabled during reset");
        check(rstout_oe, 1, "R7", "reset-output enable");

        // Float entry with full pattern
        cur_req = "R3";
        a_pin = 1'b0;
        f_pin = 1'b1;
        tick(3);
        rst_pin = 1'b0;
        tick(3);
        check(port_preset, 0, "R3", "left reset into qualify");
        cur_req = "R11";
        tick(6);
        check(float_mode, 0, "R11", "no float without machine cycles");
        cur_req = "R3";
        pulses(HOLD);
        check(float_mode, 1, "R3", "float after hold");
        check(pin_oe, 0, "R6", "pins released in float");
        check(rstout_oe, 1, "R7", "reset-output enabled in float");

        // Ignore pins in float
        cur_req = "R6";
        a_pin = 1'b1;
        f_pin = 1'b0;
        strap = 3'b000;
        pulses(3);
        check(float_mode, 1, "R6", "float kept under pin activity");

        // Exit via reset with latency
        cur_req = "R8";
        strap = 3'b111;
        rst_pin = 1'b1;
        tick(2);
        check(float_mode, 1, "R10", "float still after two edges");
        tick(1);
        check(port_preset, 1, "R10", "reset seen on third edge");
        check(pin_oe, 1, "R8", "pins re-enabled by reset");

        // Broken pattern during qualification
        cur_req = "R4";
        a_pin = 1'b0;
        f_pin = 1'b1;
        tick(3);
        rst_pin = 1'b0;
        tick(3);
        mcyc = 1'b1;
        tick(1);
        mcyc = 1'b0;
        a_pin = 1'b1;
        tick(3);
        a_pin = 1'b0;
        pulses(3);
        check(float_mode, 0, "R4", "no float after broken pattern");
        check(pin_oe, 1, "R4", "normal pins enabled");

        // Test mode by low strap
        cur_req = "R9";
        rst_pin = 1'b1;
        strap = 3'b011;
        tick(3);
        rst_pin = 1'b0;
        tick(4);
        check(test_mode, 1, "R9", "test mode on low strap");
        check(float_mode, 0, "R9", "test wins over pattern");
        cur_req = "R2";
        strap = 3'b111;
        pulses(3);
        check(test_mode, 1, "R2", "later strap change ignored");

        // Normal without pattern
        cur_req = "R5";
        rst_pin = 1'b1;
        a_pin = 1'b1;
        tick(3);
        rst_pin = 1'b0;
        tick(4);
        check(port_preset, 0, "R5", "left reset");
        check(test_mode, 0, "R5", "not test");
        cur_req = "R2";
        strap = 3'b000;
        a_pin = 1'b0;
        pulses(3);
        check(test_mode, 0, "R2", "strap low after release ignored");
        check(float_mode, 0, "R5", "normal held");

        finish_run();
    end

endmodule